// File: doc/BRIEF.md
# Entropy Bit Sampler and Password Assembler

The block turns a noisy entropy source into a 64-bit password when a user presses a button. Several free-running oscillator taps come in on a bus. Each tap is captured by its own flip-flop, and the captured taps are XOR-folded into a single raw bit. That bit is asynchronous to the system clock, so it passes through a two-flop synchronizer before anything uses it.

A falling edge on the active-low push button starts one collection run. During the run the block takes exactly one sample every `INTERVAL_CYCLES` clocks. The default is 1,250,000 clocks, which is 10 ms at 125 MHz. Neighbouring samples are correlated, so the block never samples on consecutive cycles.

Samples are packed in two levels. Eight bits form one character, filled most significant bit first. Eight characters form the password, with character 0 in the lowest byte. After the last bit, the password is shown together with a one-cycle valid strobe, and the block goes back to waiting for the next press.

Top module: `entropy_pw_collector`

## Requirements
- R1: After reset, `password` is all zeros and `password_valid` is low.
- R2: Each sampled bit equals the XOR of all `osc_taps` lines, taken three clocks before the sampling edge. The three clocks are the tap register and the two synchronizer stages.
- R3: The block is idle until it sees a press. A rising edge of `btn_n` (a release) does not start a run. While idle, `password` keeps its value and `password_valid` stays low.
- R4: A press is detected two clocks after `btn_n` falls, and the run starts on the clock after that. Samples are taken `INTERVAL_CYCLES` clocks apart. The first sample is taken `INTERVAL_CYCLES` clocks after the run starts, so the 64th sample lands on clock 3 + 64·`INTERVAL_CYCLES` after the falling edge is first registered.
- R5: Within a character, the first sampled bit goes to bit 7 and the eighth sampled bit goes to bit 0.
- R6: Character c (samples 8c to 8c+7) occupies `password[8c+7:8c]`.
- R7: `password_valid` is high for exactly one cycle, on the clock that stores the 64th sample. The block then returns to idle, and `password` holds its value until the next run writes it.
- R8: A press that arrives during a run is ignored. It does not restart the run, does not shift the sample times, and does not start a second run after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Asynchronous push button, low while pressed |
| osc_taps | input | N_TAPS | Asynchronous oscillator tap outputs |
| password | output | CHAR_BITS*NUM_CHARS | Assembled password, character 0 in the low byte |
| password_valid | output | 1 | One-cycle strobe on password completion |

## Verification
The bench uses an 8-cycle interval. It counts clock edges from the one that first registers the press. The strobe and the final word are due at edge 3 + 64·8. The bench checks that the strobe is low one cycle earlier and has dropped one cycle later. Each tap pattern is driven two edges after a sample slot opens and held for the whole interval. The sample reads the taps three edges before its own edge, so a stable value is seen even if the latency were off by a cycle or two. All outputs are read on the falling clock edge.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;

    always_comb begin
        stage_d = {stage_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/tap_combiner.sv
module tap_combiner #(
    parameter int N_TAPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TAPS-1:0] taps,
    output logic              mixed
);
    logic [N_TAPS-1:0] tap_q;
    logic [N_TAPS-1:0] tap_d;

    // one capture flop per oscillator tap
    genvar g;
    generate
        for (g = 0; g < N_TAPS; g++) begin : g_tap
            always_comb tap_d[g] = taps[g];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tap_q[g] <= 1'b0;
                else        tap_q[g] <= tap_d[g];
            end
        end
    endgenerate

    assign mixed = ^tap_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int INTERVAL = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(INTERVAL + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = '0;
        if (run && !tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
endmodule

// File: rtl/pw_assembler.sv
module pw_assembler
    import pw_pkg::*;
#(
    parameter int CHAR_BITS = 8,
    parameter int NUM_CHARS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          tick,
    input  logic                          bit_in,
    output logic                          running,
    output logic [CHAR_BITS*NUM_CHARS-1:0] pw,
    output logic                          valid
);
    localparam int PW_W  = CHAR_BITS * NUM_CHARS;
    localparam int BIT_W = (CHAR_BITS > 1) ? $clog2(CHAR_BITS) : 1;
    localparam int CHR_W = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1;
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CHAR_BITS - 1);
    localparam logic [CHR_W-1:0] CHR_LAST = CHR_W'(NUM_CHARS - 1);

    typedef struct packed {
        run_state_e           state;
        logic [BIT_W-1:0]     bit_idx;
        logic [CHR_W-1:0]     chr_idx;
        logic [CHAR_BITS-1:0] chr;
        logic [PW_W-1:0]      pw;
        logic                 valid;
    } asm_t;

    asm_t s_q, s_d;
    logic [CHAR_BITS-1:0] chr_next;

    always_comb begin
        s_d      = s_q;
        s_d.valid = 1'b0;
        chr_next = {s_q.chr[CHAR_BITS-2:0], bit_in};
        case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.state   = ST_RUN;
                    s_d.bit_idx = '0;
                    s_d.chr_idx = '0;
                    s_d.chr     = '0;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    s_d.chr     = chr_next;
                    s_d.bit_idx = s_q.bit_idx + 1'b1;
                    if (s_q.bit_idx == BIT_LAST) begin
                        s_d.bit_idx = '0;
                        s_d.pw[int'(s_q.chr_idx)*CHAR_BITS +: CHAR_BITS] = chr_next;
                        s_d.chr_idx = s_q.chr_idx + 1'b1;
                        if (s_q.chr_idx == CHR_LAST) begin
                            s_d.state   = ST_IDLE;
                            s_d.chr_idx = '0;
                            s_d.valid   = 1'b1;
                        end
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state   <= ST_IDLE;
            s_q.bit_idx <= '0;
            s_q.chr_idx <= '0;
            s_q.chr     <= '0;
            s_q.pw      <= '0;
            s_q.valid   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign running = (s_q.state == ST_RUN);
    assign pw      = s_q.pw;
    assign valid   = s_q.valid;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |=> !s_q.valid); // R7
    AST_VALID_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.valid) |-> (s_q.state == ST_IDLE && $past(s_q.state == ST_RUN))); // R7
    AST_PRESS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_RUN && start && !tick) |=> (s_q.state == ST_RUN)); // R8
    AST_TICK_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (s_q.state == ST_RUN)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_IDLE) |=> $stable(s_q.pw)); // R3
endmodule

// File: rtl/entropy_pw_collector.sv
module entropy_pw_collector #(
    parameter int N_TAPS          = 4,
    parameter int INTERVAL_CYCLES = 1250000,
    parameter int CHAR_BITS       = 8,
    parameter int NUM_CHARS       = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           btn_n,
    input  logic [N_TAPS-1:0]              osc_taps,
    output logic [CHAR_BITS*NUM_CHARS-1:0] password,
    output logic                           password_valid
);
    logic mixed_bit;
    logic sample_bit;
    logic btn_sync;
    logic btn_prev_q;
    logic btn_prev_d;
    logic btn_fall;
    logic running;
    logic tick;

    tap_combiner #(.N_TAPS(N_TAPS)) u_mix (
        .clk(clk), .rst_n(rst_n), .taps(osc_taps), .mixed(mixed_bit)
    );

    sync_chain #(.STAGES(2), .RESET_VAL(1'b0)) u_bit_sync (
        .clk(clk), .rst_n(rst_n), .din(mixed_bit), .dout(sample_bit)
    );

    sync_chain #(.STAGES(2), .RESET_VAL(1'b1)) u_btn_sync (
        .clk(clk), .rst_n(rst_n), .din(btn_n), .dout(btn_sync)
    );

    always_comb begin
        btn_prev_d = btn_sync;
        btn_fall   = btn_prev_q && !btn_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) btn_prev_q <= 1'b1;
        else        btn_prev_q <= btn_prev_d;
    end

    interval_timer #(.INTERVAL(INTERVAL_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(running), .tick(tick)
    );

    pw_assembler #(.CHAR_BITS(CHAR_BITS), .NUM_CHARS(NUM_CHARS)) u_asm (
        .clk(clk), .rst_n(rst_n), .start(btn_fall), .tick(tick),
        .bit_in(sample_bit), .running(running), .pw(password),
        .valid(password_valid)
    );

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        btn_fall |=> !btn_fall); // R3
endmodule

// File: tb/entropy_pw_collector_tb.sv
`timescale 1ns/1ps
module entropy_pw_collector_tb;
    localparam int NT = 3;
    localparam int IV = 8;
    localparam int PW_W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic [NT-1:0] taps = '0;
    logic [PW_W-1:0] password;
    logic password_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    entropy_pw_collector #(
        .N_TAPS(NT), .INTERVAL_CYCLES(IV), .CHAR_BITS(8), .NUM_CHARS(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .osc_taps(taps),
        .password(password), .password_valid(password_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NT-1:0] tap_val(input int r, input int k, input int mode);
        case (mode)
            1:       return 3'b001;
            2:       return (k % 2 == 0) ? 3'b011 : 3'b111;
            default: return NT'((k + 3 * r + k / 8) % 8);
        endcase
    endfunction

    // one full run; mid_press adds a release and second press during assembly
    task automatic run_pw(input int r, input int mode, input bit mid_press,
                          output logic [63:0] exp);
        exp = '0;
        @(negedge clk) btn_n = 1'b0;
        repeat (3) @(posedge clk);
        for (int k = 0; k < 64; k++) begin
            logic [NT-1:0] tv;
            repeat (2) @(posedge clk);
            #1;
            tv = tap_val(r, k, mode);
            taps = tv;
            exp[8 * (k / 8) + 7 - (k % 8)] = ^tv;
            if (mid_press && k == 10) btn_n = 1'b1;
            if (mid_press && k == 20) btn_n = 1'b0;
            if (k < 63) repeat (IV - 2) @(posedge clk);
            else begin
                repeat (IV - 3) @(posedge clk);
                @(negedge clk);
                check(password_valid == 1'b0, "R4 strobe early", 64'(password_valid), 64'd0);
                @(posedge clk);
            end
        end
        @(negedge clk);
        check(password_valid == 1'b1, "R4 strobe on 64th sample", 64'(password_valid), 64'd1);
        check(password == exp, "R2 password value", password, exp);
        for (int c = 0; c < 8; c++)
            check(password[8*c +: 8] == exp[8*c +: 8], "R6 character slot",
                  64'(password[8*c +: 8]), 64'(exp[8*c +: 8]));
        @(negedge clk);
        check(password_valid == 1'b0, "R7 strobe one cycle", 64'(password_valid), 64'd0);
        btn_n = 1'b1;
    endtask

    task automatic idle_watch(input int cycles, input logic [63:0] hold, input string req);
        bit bad = 1'b0;
        logic [63:0] seen = '0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            taps = NT'(i);
            if (password_valid || password != hold) begin
                bad = 1'b1;
                seen = password;
            end
        end
        check(!bad, req, seen, hold);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [63:0] exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(password == 64'd0, "R1 reset password", password, 64'd0);
        check(password_valid == 1'b0, "R1 reset strobe", 64'(password_valid), 64'd0);
        rst_n = 1'b1;
        idle_watch(5 * IV, 64'd0, "R3 no run without press");

        for (int r = 0; r < 3; r++) begin
            run_pw(r, 0, 1'b0, exp);
            idle_watch(4 * IV, exp, "R3 release does not start, R7 password held");
        end

        run_pw(0, 1, 1'b0, exp);
        check(exp == {64{1'b1}}, "R2 odd parity taps give ones", exp, {64{1'b1}});
        idle_watch(2 * IV, exp, "R7 hold after all-ones");

        run_pw(0, 2, 1'b0, exp);
        check(password == {8{8'h55}}, "R5 MSB-first character order", password, {8{8'h55}});
        idle_watch(2 * IV, exp, "R7 hold after alternating");

        run_pw(5, 0, 1'b1, exp);
        idle_watch(70 * IV, exp, "R8 mid-run press starts no second run");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule